// File: doc/BRIEF.md
# I2C Slave Byte Controller with Clock-Stretch Wait and Acknowledge Control

This block is the byte-level engine of an I2C target device. A fast system clock oversamples the open-drain SCL and SDA lines through two-flop synchronisers. Start and stop conditions are detected on the synchronised lines. After a start, the block shifts in the first byte and treats it as an address. It then moves on to received data bytes, or to transmitted data bytes when the master has addressed it for a read. At the end of each byte it decides whether to pull SDA low as an acknowledge. It stretches the clock by holding SCL low, and at that moment it raises a one-cycle interrupt request so that firmware can service the byte.

A wait-timing control picks where the wait and interrupt land for data bytes: the falling edge of the 8th clock or of the 9th. Address bytes follow fixed rules of their own:

- A matching local address is always acknowledged and always waits after the 9th clock.
- An extension-code byte waits after the 8th clock, and its acknowledge follows the acknowledge-enable control.

Firmware ends a wait either by writing the data register, which also loads the next byte to transmit, or by pulsing a wait-release input. A stop condition can also raise the interrupt when that is enabled.

Top module: `i2cw_slave`

## Requirements
- R1: After reset, scl_drive_low, sda_drive_low, irq, addr_match, ext_code, dir_read and last_ack_rx are all 0. The three controls stop_irq_en, wait_at_ninth and ack_en are inputs driven low by the system after reset.
- R2: A stop condition (SDA rising while SCL is high) pulses irq for exactly one cycle when stop_irq_en is 1, and does not pulse it when stop_irq_en is 0. irq is never high on two consecutive cycles.
- R3: For an address byte, bits 7..1 are compared with own_addr and bit 0 is the direction (1 = master reads). On a match, addr_match is set, dir_read takes bit 0, and irq pulses and SCL is held low after the 9th clock's falling edge, whatever wait_at_ninth is.
- R4: For an address byte, the acknowledge (SDA low during the 9th clock) is given only on a match and does not depend on ack_en. A non-matching address gets no acknowledge, no irq and no wait, and the following bytes are ignored until the next start.
- R5: An address byte whose bits 7..3 are 11110 is an extension code. It sets ext_code instead of addr_match, pulses irq and holds SCL low after the 8th clock's falling edge, acknowledges only if ack_en is 1, and the bytes after it are handled as received data.
- R6: For a received data byte with wait_at_ninth = 0, irq pulses and SCL is held after the 8th clock's falling edge, and rx_data then shows the byte (first bit received = bit 7).
- R7: For a received data byte with wait_at_ninth = 1, nothing happens at the 8th clock. irq pulses and SCL is held after the 9th clock's falling edge, and rx_data shows the byte.
- R8: For a received data byte, SDA is pulled low during the 9th clock exactly when ack_en is 1.
- R9: While held, SCL stays low even when the master releases it, so the next clock cannot start. A one-cycle data_wr or wait_release ends the hold.
- R10: After a read-address match, the byte written through data_wr is shifted out MSB first. SDA is released during the 9th clock, and last_ack_rx becomes 1 if the master pulled SDA low there and 0 otherwise. After a not-acknowledge, the slave releases SDA for the rest of the transfer.
- R11: A repeated start clears addr_match, ext_code and dir_read and begins a new address phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| scl_drive_low | output | 1 | 1 pulls SCL low (clock stretch) |
| sda_drive_low | output | 1 | 1 pulls SDA low (acknowledge or transmit 0) |
| own_addr | input | 7 | Local 7-bit address |
| stop_irq_en | input | 1 | Raise irq on a stop condition |
| wait_at_ninth | input | 1 | 0: data-byte wait after 8th clock, 1: after 9th |
| ack_en | input | 1 | Acknowledge received data and extension codes |
| data_wr | input | 1 | One-cycle data register write; also releases the wait |
| data_wdata | input | 8 | Byte to transmit |
| wait_release | input | 1 | One-cycle wait release without a data write |
| rx_data | output | 8 | Last byte received |
| irq | output | 1 | One-cycle interrupt request |
| addr_match | output | 1 | Local address matched since the last start |
| ext_code | output | 1 | Extension code received since the last start |
| dir_read | output | 1 | Direction bit of the matched address |
| last_ack_rx | output | 1 | 1 if the master acknowledged the last transmitted byte |

## Verification
The bench sweeps all 128 address values at both wait timings. This catches a design that waits on a mismatched address, applies the data-byte timing to the address byte, lets ack_en gate the address acknowledge, or misses the extension-code range. Each combination of wait timing, acknowledge enable and release method is run on data bytes. With the 8th-clock wait, the master raises SCL and the bench checks that the line stays low until the release, which catches a hold that lets the 9th clock through. Slave transmit is run with an acknowledged byte followed by a not-acknowledged one, which exposes a wrong last_ack_rx polarity or a slave that keeps driving SDA. Stop interrupts and repeated starts are checked for their enable gating and for the clearing of the status flags.

// File: rtl/i2cw_pkg.sv
package i2cw_pkg;

    localparam int unsigned BYTE_W   = 8;
    localparam int unsigned ADDR_W   = BYTE_W - 1;
    localparam int unsigned BITCNT_W = $clog2(BYTE_W + 2);

    localparam logic [BITCNT_W-1:0] LAST_BIT = BITCNT_W'(BYTE_W);
    localparam logic [BITCNT_W-1:0] ACK_BIT  = BITCNT_W'(BYTE_W + 1);

    localparam logic [4:0] EXT_PREFIX = 5'b11110;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_ADDR,
        PH_RX,
        PH_TX
    } phase_e;

    typedef enum logic [1:0] {
        ACK_NONE,
        ACK_FORCE,
        ACK_BY_EN
    } ack_e;

    typedef struct packed {
        logic start;
        logic stop;
        logic rise;
        logic fall;
        logic sda;
    } bus_ev_t;

    function automatic logic is_ext_code(input logic [BYTE_W-1:0] b);
        return b[BYTE_W-1 -: 5] == EXT_PREFIX;
    endfunction

endpackage

// File: rtl/i2cw_sync.sv
module i2cw_sync #(
    parameter int unsigned WIDTH  = 2,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    for (genvar i = 0; i < WIDTH; i++) begin : g_line
        logic [STAGES-1:0] ff;
        always_ff @(posedge clk) begin
            if (rst) ff <= '1;
            else     ff <= {ff[STAGES-2:0], din[i]};
        end
        assign dout[i] = ff[STAGES-1];
    end
endmodule

// File: rtl/i2cw_bus_events.sv
module i2cw_bus_events
    import i2cw_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    scl_s,
    input  logic    sda_s,
    output bus_ev_t ev
);
    logic scl_q, sda_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_s;
            sda_q <= sda_s;
        end
    end

    always_comb begin
        ev.rise  = !scl_q && scl_s;
        ev.fall  = scl_q && !scl_s;
        ev.start = scl_q && scl_s && sda_q && !sda_s;
        ev.stop  = scl_q && scl_s && !sda_q && sda_s;
        ev.sda   = sda_s;
    end
endmodule

// File: rtl/i2cw_byte_fsm.sv
module i2cw_byte_fsm
    import i2cw_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  bus_ev_t           ev,
    input  logic [ADDR_W-1:0] own_addr,
    input  logic              stop_irq_en,
    input  logic              wait_at_ninth,
    input  logic              ack_en,
    input  logic              data_wr,
    input  logic [BYTE_W-1:0] data_wdata,
    input  logic              wait_release,
    output logic              scl_low,
    output logic              sda_low,
    output logic [BYTE_W-1:0] rx_data,
    output logic              irq,
    output logic              addr_match,
    output logic              ext_code,
    output logic              dir_read,
    output logic              last_ack_rx
);
    phase_e              phase;
    ack_e                ack_mode;
    logic [BITCNT_W-1:0] bitcnt;
    logic [BYTE_W-1:0]   shreg;
    logic [BYTE_W-1:0]   txsh;
    logic                in_slot;
    logic                hold;
    logic                irq_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase       <= PH_IDLE;
            ack_mode    <= ACK_NONE;
            bitcnt      <= '0;
            shreg       <= '0;
            txsh        <= '1;
            in_slot     <= 1'b0;
            hold        <= 1'b0;
            irq_q       <= 1'b0;
            rx_data     <= '0;
            addr_match  <= 1'b0;
            ext_code    <= 1'b0;
            dir_read    <= 1'b0;
            last_ack_rx <= 1'b0;
        end else begin
            irq_q <= 1'b0;
            if (data_wr) txsh <= data_wdata;
            if (data_wr || wait_release) hold <= 1'b0;

            if (ev.stop) begin
                phase    <= PH_IDLE;
                hold     <= 1'b0;
                ack_mode <= ACK_NONE;
                in_slot  <= 1'b0;
                bitcnt   <= '0;
                if (stop_irq_en) irq_q <= 1'b1;
            end else if (ev.start) begin
                phase      <= PH_ADDR;
                hold       <= 1'b0;
                ack_mode   <= ACK_NONE;
                in_slot    <= 1'b0;
                bitcnt     <= '0;
                addr_match <= 1'b0;
                ext_code   <= 1'b0;
                dir_read   <= 1'b0;
            end else if (phase != PH_IDLE) begin
                if (ev.rise) begin
                    if (bitcnt < LAST_BIT) shreg <= {shreg[BYTE_W-2:0], ev.sda};
                    else if (phase == PH_TX) last_ack_rx <= !ev.sda;
                    if (bitcnt < ACK_BIT) bitcnt <= bitcnt + 1'b1;
                end else if (ev.fall) begin
                    if (bitcnt == LAST_BIT) begin
                        in_slot <= 1'b1;
                        unique case (phase)
                            PH_ADDR: begin
                                rx_data <= shreg;
                                if (is_ext_code(shreg)) begin
                                    ext_code <= 1'b1;
                                    ack_mode <= ACK_BY_EN;
                                    irq_q    <= 1'b1;
                                    hold     <= 1'b1;
                                end else if (shreg[BYTE_W-1:1] == own_addr) begin
                                    addr_match <= 1'b1;
                                    dir_read   <= shreg[0];
                                    ack_mode   <= ACK_FORCE;
                                end else begin
                                    phase   <= PH_IDLE;
                                    in_slot <= 1'b0;
                                end
                            end
                            PH_RX: begin
                                rx_data  <= shreg;
                                ack_mode <= ACK_BY_EN;
                                if (!wait_at_ninth) begin
                                    irq_q <= 1'b1;
                                    hold  <= 1'b1;
                                end
                            end
                            PH_TX: begin
                                ack_mode <= ACK_NONE;
                                if (!data_wr) txsh <= {txsh[BYTE_W-2:0], 1'b1};
                                if (!wait_at_ninth) begin
                                    irq_q <= 1'b1;
                                    hold  <= 1'b1;
                                end
                            end
                            default: ;
                        endcase
                    end else if (bitcnt == ACK_BIT) begin
                        bitcnt   <= '0;
                        ack_mode <= ACK_NONE;
                        in_slot  <= 1'b0;
                        unique case (phase)
                            PH_ADDR: begin
                                if (ext_code) begin
                                    phase <= PH_RX;
                                end else begin
                                    irq_q <= 1'b1;
                                    hold  <= 1'b1;
                                    phase <= dir_read ? PH_TX : PH_RX;
                                end
                            end
                            PH_RX: begin
                                if (wait_at_ninth) begin
                                    irq_q <= 1'b1;
                                    hold  <= 1'b1;
                                end
                            end
                            PH_TX: begin
                                if (wait_at_ninth) begin
                                    irq_q <= 1'b1;
                                    hold  <= 1'b1;
                                end
                                if (!last_ack_rx) phase <= PH_IDLE;
                            end
                            default: ;
                        endcase
                    end else if (phase == PH_TX && bitcnt != '0 && !data_wr) begin
                        txsh <= {txsh[BYTE_W-2:0], 1'b1};
                    end
                end
            end
        end
    end

    always_comb begin
        scl_low = hold;
        irq     = irq_q;
        sda_low = (in_slot && (ack_mode == ACK_FORCE || (ack_mode == ACK_BY_EN && ack_en)))
                || (phase == PH_TX && !in_slot && !txsh[BYTE_W-1]);
    end
endmodule

// File: rtl/i2cw_slave.sv
module i2cw_slave
    import i2cw_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              scl_drive_low,
    output logic              sda_drive_low,
    input  logic [ADDR_W-1:0] own_addr,
    input  logic              stop_irq_en,
    input  logic              wait_at_ninth,
    input  logic              ack_en,
    input  logic              data_wr,
    input  logic [BYTE_W-1:0] data_wdata,
    input  logic              wait_release,
    output logic [BYTE_W-1:0] rx_data,
    output logic              irq,
    output logic              addr_match,
    output logic              ext_code,
    output logic              dir_read,
    output logic              last_ack_rx
);
    logic [1:0] lines_s;
    bus_ev_t    ev;

    i2cw_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  ({scl_i, sda_i}),
        .dout (lines_s)
    );

    i2cw_bus_events u_ev (
        .clk   (clk),
        .rst   (rst),
        .scl_s (lines_s[1]),
        .sda_s (lines_s[0]),
        .ev    (ev)
    );

    i2cw_byte_fsm u_fsm (
        .clk           (clk),
        .rst           (rst),
        .ev            (ev),
        .own_addr      (own_addr),
        .stop_irq_en   (stop_irq_en),
        .wait_at_ninth (wait_at_ninth),
        .ack_en        (ack_en),
        .data_wr       (data_wr),
        .data_wdata    (data_wdata),
        .wait_release  (wait_release),
        .scl_low       (scl_drive_low),
        .sda_low       (sda_drive_low),
        .rx_data       (rx_data),
        .irq           (irq),
        .addr_match    (addr_match),
        .ext_code      (ext_code),
        .dir_read      (dir_read),
        .last_ack_rx   (last_ack_rx)
    );
endmodule

// File: rtl/i2cw_slave_chk.sv
module i2cw_slave_chk (
    input logic clk,
    input logic rst,
    input logic scl_i,
    input logic irq,
    input logic scl_drive_low,
    input logic sda_drive_low,
    input logic data_wr,
    input logic wait_release,
    input logic addr_match,
    input logic ext_code
);
    // R2
    irq_single_cycle_chk: assert property (@(posedge clk) disable iff (rst)
        irq |=> !irq);

    // R6 R7
    hold_with_irq_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(scl_drive_low) |-> irq);

    // R9
    release_ends_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (scl_drive_low && (data_wr || wait_release)) |=> !scl_drive_low);

    // R8
    sda_moves_while_scl_low_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(sda_drive_low) |-> !scl_i);

    // R5
    ext_excludes_match_chk: assert property (@(posedge clk) disable iff (rst)
        !(addr_match && ext_code));
endmodule

bind i2cw_slave i2cw_slave_chk u_chk (
    .clk           (clk),
    .rst           (rst),
    .scl_i         (scl_i),
    .irq           (irq),
    .scl_drive_low (scl_drive_low),
    .sda_drive_low (sda_drive_low),
    .data_wr       (data_wr),
    .wait_release  (wait_release),
    .addr_match    (addr_match),
    .ext_code      (ext_code)
);

// File: tb/i2cw_slave_tb.sv
module i2cw_slave_tb;
    localparam int Q = 10;
    localparam logic [6:0] OWN = 7'h2A;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #4 clk = ~clk;

    logic m_scl = 1'b1, m_sda = 1'b1;
    logic scl_drive_low, sda_drive_low;
    logic stop_irq_en = 0, wait_at_ninth = 0, ack_en = 0;
    logic data_wr = 0, wait_release = 0;
    logic [7:0] data_wdata = 0;
    logic [7:0] rx_data;
    logic irq, addr_match, ext_code, dir_read, last_ack_rx;
    wire scl_line = m_scl & ~scl_drive_low;
    wire sda_line = m_sda & ~sda_drive_low;

    i2cw_slave u_dut (
        .clk(clk), .rst(rst), .scl_i(scl_line), .sda_i(sda_line),
        .scl_drive_low(scl_drive_low), .sda_drive_low(sda_drive_low),
        .own_addr(OWN), .stop_irq_en(stop_irq_en), .wait_at_ninth(wait_at_ninth),
        .ack_en(ack_en), .data_wr(data_wr), .data_wdata(data_wdata),
        .wait_release(wait_release), .rx_data(rx_data), .irq(irq),
        .addr_match(addr_match), .ext_code(ext_code), .dir_read(dir_read),
        .last_ack_rx(last_ack_rx)
    );

    int n_cmp = 0, n_bad = 0;
    int irq_cnt = 0, irq_wide = 0;
    logic irq_prev = 0;
    logic done = 0;

    always @(posedge clk) begin
        if (rst) begin
            irq_cnt <= 0;
            irq_prev <= 0;
        end else begin
            if (irq) irq_cnt <= irq_cnt + 1;
            if (irq && irq_prev) irq_wide <= irq_wide + 1;
            irq_prev <= irq;
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input int act, input int exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic scl_up();
        m_scl = 1'b1;
        tick(1);
        while (!scl_line) tick(1);
    endtask

    task automatic bus_start();
        m_sda = 1'b1; tick(Q);
        scl_up(); tick(Q);
        m_sda = 1'b0; tick(Q);
        m_scl = 1'b0; tick(Q);
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; tick(Q);
        scl_up(); tick(Q);
        m_sda = 1'b1; tick(Q);
    endtask

    task automatic clk_bit(input logic b, output logic s);
        m_sda = b; tick(Q);
        scl_up(); tick(Q / 2);
        s = sda_line; tick(Q / 2);
        m_scl = 1'b0; tick(Q);
    endtask

    task automatic send8(input logic [7:0] v);
        logic s;
        for (int i = 7; i >= 0; i--) clk_bit(v[i], s);
    endtask

    task automatic recv8(output logic [7:0] v);
        logic s;
        for (int i = 7; i >= 0; i--) begin
            clk_bit(1'b1, s);
            v[i] = s;
        end
    endtask

    task automatic do_release(input int use_wr);
        if (use_wr != 0) begin
            data_wr = 1'b1;
            data_wdata = 8'hFF;
        end else begin
            wait_release = 1'b1;
        end
        tick(1);
        data_wr = 1'b0;
        wait_release = 1'b0;
        tick(2);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic s;
        logic [7:0] v;
        int c0;
        tick(5);
        rst = 1'b0;
        tick(5);

        // R1 reset state
        chk("R1 scl_drive_low", scl_drive_low, 0);
        chk("R1 sda_drive_low", sda_drive_low, 0);
        chk("R1 irq count", irq_cnt, 0);
        chk("R1 addr_match", addr_match, 0);
        chk("R1 ext_code", ext_code, 0);
        chk("R1 dir_read", dir_read, 0);
        chk("R1 last_ack_rx", last_ack_rx, 0);

        // R3 R4 R5 sweep over every 7-bit address, write direction
        for (int a = 0; a < 128; a++) begin
            logic is_ext, is_match;
            is_ext = (a[6:2] == 5'b11110);
            is_match = (a[6:0] == OWN);
            wait_at_ninth = a[0];
            ack_en = 1'b0;
            bus_start();
            c0 = irq_cnt;
            send8({a[6:0], 1'b0});
            chk("R5 irq at 8th", irq_cnt - c0, int'(is_ext));
            chk("R5 hold at 8th", scl_drive_low, int'(is_ext));
            if (is_ext) do_release(0);
            clk_bit(1'b1, s);
            chk("R4 address ack", s, int'(!is_match));
            chk("R3 irq after 9th", irq_cnt - c0, int'(is_ext || is_match));
            chk("R3 hold after 9th", scl_drive_low, int'(is_match));
            chk("R3 addr_match", addr_match, int'(is_match));
            chk("R5 ext_code", ext_code, int'(is_ext));
            if (is_match) do_release(0);
            if (!is_match && !is_ext && a[2:0] == 3'd0) begin
                c0 = irq_cnt;
                wait_at_ninth = 1'b0;
                send8(8'h00);
                clk_bit(1'b1, s);
                chk("R4 ignored byte ack", s, 1);
                chk("R4 ignored byte irq", irq_cnt - c0, 0);
                chk("R4 ignored byte hold", scl_drive_low, 0);
            end
            c0 = irq_cnt;
            bus_stop();
            tick(Q);
            chk("R2 stop irq disabled", irq_cnt - c0, 0);
        end

        // R6 R7 R8 R9 data reception across timing, ack enable and release method
        for (int cfg = 0; cfg < 8; cfg++) begin
            wait_at_ninth = cfg[0];
            ack_en = cfg[1];
            bus_start();
            send8({OWN, 1'b0});
            clk_bit(1'b1, s);
            do_release(cfg[2]);
            for (int k = 0; k < 2; k++) begin
                v = 8'h5A ^ 8'((cfg * 37 + k * 101) & 255);
                c0 = irq_cnt;
                send8(v);
                if (!wait_at_ninth) begin
                    chk("R6 irq at 8th", irq_cnt - c0, 1);
                    chk("R6 hold at 8th", scl_drive_low, 1);
                    chk("R6 rx_data", rx_data, v);
                    m_sda = 1'b1; tick(Q);
                    m_scl = 1'b1; tick(20);
                    chk("R9 ninth clock stretched", scl_line, 0);
                    do_release(cfg[2]);
                    chk("R9 hold ended", scl_drive_low, 0);
                    scl_up(); tick(Q / 2);
                    s = sda_line; tick(Q / 2);
                    m_scl = 1'b0; tick(Q);
                    chk("R8 data ack", s, int'(!ack_en));
                    chk("R6 no second irq", irq_cnt - c0, 1);
                end else begin
                    chk("R7 no irq at 8th", irq_cnt - c0, 0);
                    chk("R7 no hold at 8th", scl_drive_low, 0);
                    clk_bit(1'b1, s);
                    chk("R8 data ack", s, int'(!ack_en));
                    chk("R7 irq at 9th", irq_cnt - c0, 1);
                    chk("R7 hold at 9th", scl_drive_low, 1);
                    chk("R7 rx_data", rx_data, v);
                    do_release(cfg[2]);
                    chk("R9 hold ended", scl_drive_low, 0);
                end
            end
            bus_stop();
        end

        // R5 extension code with ack enabled, then a data byte
        ack_en = 1'b1;
        wait_at_ninth = 1'b0;
        bus_start();
        c0 = irq_cnt;
        send8(8'hF2);
        chk("R5 ext irq", irq_cnt - c0, 1);
        chk("R5 ext hold", scl_drive_low, 1);
        do_release(1);
        clk_bit(1'b1, s);
        chk("R5 ext ack with ack_en", s, 0);
        chk("R5 ext no 9th irq", irq_cnt - c0, 1);
        send8(8'h96);
        chk("R5 data after ext", rx_data, 8'h96);
        chk("R5 data after ext irq", irq_cnt - c0, 2);
        do_release(0);
        clk_bit(1'b1, s);
        bus_stop();

        // R10 slave transmit
        wait_at_ninth = 1'b1;
        ack_en = 1'b0;
        bus_start();
        c0 = irq_cnt;
        send8({OWN, 1'b1});
        clk_bit(1'b1, s);
        chk("R10 read address ack", s, 0);
        chk("R3 dir_read", dir_read, 1);
        chk("R3 read irq", irq_cnt - c0, 1);
        data_wr = 1'b1; data_wdata = 8'hC3; tick(1);
        data_wr = 1'b0; tick(2);
        chk("R9 data write releases", scl_drive_low, 0);
        recv8(v);
        chk("R10 first byte", v, 8'hC3);
        clk_bit(1'b0, s);
        chk("R10 master ack seen", last_ack_rx, 1);
        chk("R10 irq at 9th", irq_cnt - c0, 2);
        data_wr = 1'b1; data_wdata = 8'h5E; tick(1);
        data_wr = 1'b0; tick(2);
        recv8(v);
        chk("R10 second byte", v, 8'h5E);
        clk_bit(1'b1, s);
        chk("R10 master nack seen", last_ack_rx, 0);
        do_release(0);
        c0 = irq_cnt;
        recv8(v);
        chk("R10 released after nack", v, 8'hFF);
        chk("R10 idle after nack", irq_cnt - c0, 0);
        bus_stop();

        // R11 repeated start clears status
        wait_at_ninth = 1'b0;
        bus_start();
        send8({OWN, 1'b1});
        clk_bit(1'b1, s);
        do_release(0);
        chk("R11 matched before restart", addr_match, 1);
        bus_start();
        chk("R11 addr_match cleared", addr_match, 0);
        chk("R11 dir_read cleared", dir_read, 0);
        send8({OWN, 1'b0});
        clk_bit(1'b1, s);
        chk("R11 new address ack", s, 0);
        do_release(0);

        // R2 stop interrupt enabled
        stop_irq_en = 1'b1;
        c0 = irq_cnt;
        bus_stop();
        tick(Q);
        chk("R2 stop irq enabled", irq_cnt - c0, 1);
        chk("R2 irq single cycle", irq_wide, 0);

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule